// File: doc/BRIEF.md
# Fault Status Capture Register

This block keeps a sticky record of usage and bus faults raised by a small processor core, together with the bus address of the most recent bus fault whose address was known. The core reports each fault as a single-cycle pulse. The pulse carries a kind code, an address-known flag, an address and a flag that marks illegal use of the execution status state. The block turns each pulse into set bits in a 32-bit status word. When the fault is a bus fault with a known address, it also loads a separate address register and raises a valid flag in the status word.

Software reaches both registers through a one-bit-select read/write port. A read returns the chosen register one cycle after the select is presented. A write to the status register clears each bit written as one and leaves the others alone. Two inputs decide whether an unaligned access counts as a fault: a trap-enable level and the class of the faulting instruction.

Top module: `fault_capture_top`

## Requirements
- R1: Each event kind sets its own status bit. The kind codes are 1 coprocessor access (bit 19), 2 invalid PC load (bit 18), 3 invalid state (bit 17), 4 undefined instruction (bit 16) and 6 stacking bus fault (bit 12).
- R2: Every status bit outside 24, 19..15 and 12 reads as zero, including the reserved fields 23..20 and 14..13. Writing ones to those positions leaves them zero.
- R3: A status bit stays set until software writes a 1 to its position with select 0. Writing 0 to a position leaves that bit unchanged.
- R4: An unaligned event (kind 0) sets bit 24 in these cases:
  - for any class, when the trap enable is high;
  - whatever the trap enable, when the class is multi-word (1) or doubleword (2).
  With the trap enable low and class single (0) or other (3), the event changes nothing.
- R5: A bus fault (kind 5) with the address-known flag high loads the address register with the event address and sets bit 15. A bus fault with the flag low changes neither register.
- R6: A memory-management fault (kind 7) clears bit 15. It leaves the other status bits and the address register unchanged.
- R7: A stacking bus fault (kind 6) sets bit 12. It does not load the address register and does not set bit 15, even when the address-known flag is high.
- R8: The state-misuse flag sets bit 17 alongside the event's own bit, with one exception: on an undefined-instruction event (kind 4) only bit 16 is set.
- R9: Writes with select 1 do not change the address register. The register holds its value until the next known-address bus fault or reset.
- R10: After the active-low synchronous reset, both registers and the read data are zero.
- R11: When an event sets a bit in the same cycle that a write clears it, the bit ends set. Clears to other bits in that write still take effect.
- R12: The read data, one cycle after select s is presented, equals the register as it stood in that cycle (select 0 is status, select 1 is address).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtValid | input | 1 | Single-cycle fault event strobe |
| evtKind | input | 3 | Fault kind code |
| evtAddrKnown | input | 1 | Event address is meaningful |
| evtAddr | input | ADDR_W | Faulting bus address |
| evtPsrUse | input | 1 | Instruction made illegal use of execution status state |
| instrClass | input | 2 | Faulting instruction class (0 single, 1 multi-word, 2 doubleword, 3 other) |
| unalTrapEn | input | 1 | Unaligned access trapping enabled |
| regSel | input | 1 | Register select (0 status, 1 address) |
| regWrEn | input | 1 | Write strobe |
| regWrData | input | 32 | Write data (ones clear status bits) |
| regRdData | output | 32 | Registered read data |

## Verification
The assertions watch several properties on every cycle:
- the reserved positions stay zero;
- a strobe that sets a bit beats a clear of the same bit;
- bits with no set, clear or drop strobe hold their value;
- the address register changes only on a capture;
- the decode never sets bit 17 for an undefined instruction and never sets bit 24 for a gated unaligned access.

Some behaviours show only in the bench's scenarios:
- the mapping of kind codes to bit positions;
- the read latency;
- an address that survives a later memory-management fault;
- port writes that leave the address untouched.

// File: rtl/fault_capture_pkg.sv
package fault_capture_pkg;

  localparam int STAT_W    = 32;
  localparam int BIT_UNAL  = 24;
  localparam int BIT_NOCP  = 19;
  localparam int BIT_BADPC = 18;
  localparam int BIT_STATE = 17;
  localparam int BIT_UNDEF = 16;
  localparam int BIT_AVLD  = 15;
  localparam int BIT_STACK = 12;

  localparam logic [STAT_W-1:0] IMPL_MASK =
      (STAT_W'(1) << BIT_UNAL)  | (STAT_W'(1) << BIT_NOCP)  |
      (STAT_W'(1) << BIT_BADPC) | (STAT_W'(1) << BIT_STATE) |
      (STAT_W'(1) << BIT_UNDEF) | (STAT_W'(1) << BIT_AVLD)  |
      (STAT_W'(1) << BIT_STACK);

  typedef enum logic [2:0] {
    K_UNAL  = 3'd0,
    K_NOCP  = 3'd1,
    K_BADPC = 3'd2,
    K_STATE = 3'd3,
    K_UNDEF = 3'd4,
    K_BUS   = 3'd5,
    K_STACK = 3'd6,
    K_MMAN  = 3'd7
  } fault_kind_e;

  typedef enum logic [1:0] {
    C_SINGLE = 2'd0,
    C_MULTI  = 2'd1,
    C_DOUBLE = 2'd2,
    C_OTHER  = 2'd3
  } instr_class_e;

  typedef struct packed {
    logic [STAT_W-1:0] setMask;
    logic [STAT_W-1:0] clrMask;
    logic              captureAddr;
    logic              dropValid;
  } strobe_t;

endpackage

// File: rtl/fault_capture_ctrl.sv
module fault_capture_ctrl
  import fault_capture_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              evtValid,
  input  fault_kind_e       evtKind,
  input  logic              evtAddrKnown,
  input  logic              evtPsrUse,
  input  instr_class_e      instrClass,
  input  logic              unalTrapEn,
  input  logic              regSel,
  input  logic              regWrEn,
  input  logic [STAT_W-1:0] regWrData,
  output strobe_t           strb
);

  logic unalCounts;
  logic forcedClass;
  logic [STAT_W-1:0] kindMask;

  assign forcedClass = (instrClass == C_MULTI) || (instrClass == C_DOUBLE);
  assign unalCounts  = unalTrapEn || forcedClass;

  always_comb begin
    kindMask = '0;
    unique case (evtKind)
      K_UNAL:  kindMask[BIT_UNAL]  = unalCounts;
      K_NOCP:  kindMask[BIT_NOCP]  = 1'b1;
      K_BADPC: kindMask[BIT_BADPC] = 1'b1;
      K_STATE: kindMask[BIT_STATE] = 1'b1;
      K_UNDEF: kindMask[BIT_UNDEF] = 1'b1;
      K_BUS:   kindMask[BIT_AVLD]  = evtAddrKnown;
      K_STACK: kindMask[BIT_STACK] = 1'b1;
      K_MMAN:  kindMask            = '0;
      default: kindMask            = '0;
    endcase
    // state misuse rides along on any kind but an undefined instruction
    if (evtPsrUse && (evtKind != K_UNDEF)) kindMask[BIT_STATE] = 1'b1;
  end

  always_comb begin
    strb.setMask     = evtValid ? kindMask : '0;
    strb.clrMask     = (regWrEn && !regSel) ? (regWrData & IMPL_MASK) : '0;
    strb.captureAddr = evtValid && (evtKind == K_BUS) && evtAddrKnown;
    strb.dropValid   = evtValid && (evtKind == K_MMAN);
  end

  // R4
  unal_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evtValid && evtKind == K_UNAL && !unalTrapEn &&
     (instrClass == C_SINGLE || instrClass == C_OTHER)) |-> !strb.setMask[BIT_UNAL]);

  // R8
  undef_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evtValid && evtKind == K_UNDEF) |-> !strb.setMask[BIT_STATE]);

  // R2
  set_in_impl_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.setMask & ~IMPL_MASK) == '0);

  // R7
  stack_no_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evtValid && evtKind == K_STACK) |-> (!strb.captureAddr && !strb.setMask[BIT_AVLD]));

endmodule

// File: rtl/fault_capture_dp.sv
module fault_capture_dp
  import fault_capture_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] evtAddr,
  input  logic              regSel,
  output logic [STAT_W-1:0] regRdData
);

  localparam logic [STAT_W-1:0] VALID_BIT = STAT_W'(1) << BIT_AVLD;

  logic [STAT_W-1:0] statusQ, statusD;
  logic [ADDR_W-1:0] addrQ;
  logic [STAT_W-1:0] rdQ;
  logic [STAT_W-1:0] dropMask;

  assign dropMask = strb.dropValid ? VALID_BIT : '0;
  assign statusD  = ((statusQ & ~strb.clrMask & ~dropMask) | strb.setMask) & IMPL_MASK;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ <= '0;
      addrQ   <= '0;
      rdQ     <= '0;
    end else begin
      statusQ <= statusD;
      if (strb.captureAddr) addrQ <= evtAddr;
      rdQ <= regSel ? STAT_W'(addrQ) : statusQ;
    end
  end

  assign regRdData = rdQ;

  // R2
  resv_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusQ & ~IMPL_MASK) == '0);

  // R5
  addr_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.captureAddr |=> (statusQ[BIT_AVLD] && addrQ == $past(evtAddr)));

  // R9
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.captureAddr |=> $stable(addrQ));

  // R11
  set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.setMask != '0) |=> ((statusQ & $past(strb.setMask)) == $past(strb.setMask)));

  // R6
  drop_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.dropValid && !strb.setMask[BIT_AVLD]) |=> !statusQ[BIT_AVLD]);

  // R3
  sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.setMask == '0 && strb.clrMask == '0 && !strb.dropValid) |=> $stable(statusQ));

endmodule

// File: rtl/fault_capture_top.sv
module fault_capture_top
  import fault_capture_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              evtValid,
  input  logic [2:0]        evtKind,
  input  logic              evtAddrKnown,
  input  logic [ADDR_W-1:0] evtAddr,
  input  logic              evtPsrUse,
  input  logic [1:0]        instrClass,
  input  logic              unalTrapEn,
  input  logic              regSel,
  input  logic              regWrEn,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData
);

  strobe_t strb;

  fault_capture_ctrl ctrl_i (
    .clk          (clk),
    .rstN         (rstN),
    .evtValid     (evtValid),
    .evtKind      (fault_kind_e'(evtKind)),
    .evtAddrKnown (evtAddrKnown),
    .evtPsrUse    (evtPsrUse),
    .instrClass   (instr_class_e'(instrClass)),
    .unalTrapEn   (unalTrapEn),
    .regSel       (regSel),
    .regWrEn      (regWrEn),
    .regWrData    (regWrData),
    .strb         (strb)
  );

  fault_capture_dp #(.ADDR_W(ADDR_W)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .evtAddr   (evtAddr),
    .regSel    (regSel),
    .regRdData (regRdData)
  );

endmodule

// File: tb/fault_capture_tb.sv
module fault_capture_top_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        evtValid = 1'b0;
  logic [2:0]  evtKind = 3'd0;
  logic        evtAddrKnown = 1'b0;
  logic [31:0] evtAddr = '0;
  logic        evtPsrUse = 1'b0;
  logic [1:0]  instrClass = 2'd0;
  logic        unalTrapEn = 1'b0;
  logic        regSel = 1'b0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  fault_capture_top dut_i (
    .clk(clk), .rstN(rstN), .evtValid(evtValid), .evtKind(evtKind),
    .evtAddrKnown(evtAddrKnown), .evtAddr(evtAddr), .evtPsrUse(evtPsrUse),
    .instrClass(instrClass), .unalTrapEn(unalTrapEn), .regSel(regSel),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData)
  );

  typedef struct packed {
    logic [2:0]  kind;
    logic        known;
    logic [1:0]  cls;
    logic        trap;
    logic        psr;
    logic [31:0] addr;
    logic [31:0] expStat;
    logic [31:0] expAddr;
    logic [7:0]  req;
  } vec_t;

  localparam int NVEC = 15;
  localparam vec_t VECS [NVEC] = '{
    '{3'd0, 1'b0, 2'd0, 1'b0, 1'b0, 32'h2000_0010, 32'h0000_0000, 32'h0, 8'd4},  // R4 gated
    '{3'd0, 1'b0, 2'd0, 1'b1, 1'b0, 32'h2000_0014, 32'h0100_0000, 32'h0, 8'd4},  // R4 trap on
    '{3'd0, 1'b0, 2'd1, 1'b0, 1'b0, 32'h2000_0018, 32'h0100_0000, 32'h0, 8'd4},  // R4 multi
    '{3'd0, 1'b0, 2'd2, 1'b0, 1'b0, 32'h2000_001C, 32'h0100_0000, 32'h0, 8'd4},  // R4 double
    '{3'd0, 1'b0, 2'd3, 1'b0, 1'b0, 32'h2000_0020, 32'h0000_0000, 32'h0, 8'd4},  // R4 other
    '{3'd1, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0,         32'h0008_0000, 32'h0, 8'd1},  // R1
    '{3'd2, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0,         32'h0004_0000, 32'h0, 8'd1},  // R1
    '{3'd3, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0,         32'h0002_0000, 32'h0, 8'd1},  // R1
    '{3'd4, 1'b0, 2'd0, 1'b0, 1'b1, 32'h0,         32'h0001_0000, 32'h0, 8'd8},  // R8
    '{3'd1, 1'b0, 2'd0, 1'b0, 1'b1, 32'h0,         32'h000A_0000, 32'h0, 8'd8},  // R8
    '{3'd5, 1'b1, 2'd0, 1'b0, 1'b0, 32'h2000_0100, 32'h0000_8000, 32'h2000_0100, 8'd5}, // R5
    '{3'd5, 1'b0, 2'd0, 1'b0, 1'b0, 32'h2000_0104, 32'h0000_0000, 32'h0, 8'd5},  // R5 unknown
    '{3'd6, 1'b1, 2'd0, 1'b0, 1'b0, 32'h2000_0200, 32'h0000_1000, 32'h0, 8'd7},  // R7
    '{3'd7, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0,         32'h0000_0000, 32'h0, 8'd6},  // R6
    '{3'd4, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0,         32'h0001_0000, 32'h0, 8'd1}   // R1
  };

  task automatic check(input int req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; evtValid = 1'b0; regWrEn = 1'b0; regSel = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic pulse(input logic [2:0] k, input logic kn, input logic [31:0] a,
                       input logic [1:0] c, input logic t, input logic p);
    @(negedge clk);
    evtValid = 1'b1; evtKind = k; evtAddrKnown = kn; evtAddr = a;
    instrClass = c; unalTrapEn = t; evtPsrUse = p;
    @(negedge clk);
    evtValid = 1'b0; evtPsrUse = 1'b0; evtAddrKnown = 1'b0;
  endtask

  task automatic writeReg(input logic sel, input logic [31:0] d);
    @(negedge clk);
    regSel = sel; regWrEn = 1'b1; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic readReg(input logic sel, output logic [31:0] v);
    @(negedge clk);
    regSel = sel;
    @(negedge clk);
    v = regRdData;
  endtask

  initial begin
    logic [31:0] v;
    // R10 reset state
    doReset();
    readReg(1'b0, v); check(10, "status after reset", v, 32'h0);
    readReg(1'b1, v); check(10, "address after reset", v, 32'h0);
    check(10, "read data after reset", regRdData, 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      doReset();
      pulse(VECS[i].kind, VECS[i].known, VECS[i].addr, VECS[i].cls,
            VECS[i].trap, VECS[i].psr);
      readReg(1'b0, v); check(int'(VECS[i].req), $sformatf("vec %0d status", i), v, VECS[i].expStat);
      readReg(1'b1, v); check(int'(VECS[i].req), $sformatf("vec %0d address", i), v, VECS[i].expAddr);
    end

    // R3 sticky, write-one-to-clear
    doReset();
    pulse(3'd1, 1'b0, 32'h0, 2'd0, 1'b0, 1'b0);
    writeReg(1'b0, 32'h0);
    readReg(1'b0, v); check(3, "zero write keeps bit", v, 32'h0008_0000);
    writeReg(1'b0, 32'h0008_0000);
    readReg(1'b0, v); check(3, "one write clears bit", v, 32'h0);

    // R2 reserved positions ignore writes
    writeReg(1'b0, 32'hFFFF_FFFF);
    readReg(1'b0, v); check(2, "reserved stay zero", v, 32'h0);

    // R11 set beats clear in the same cycle
    pulse(3'd2, 1'b0, 32'h0, 2'd0, 1'b0, 1'b0);
    pulse(3'd1, 1'b0, 32'h0, 2'd0, 1'b0, 1'b0);
    @(negedge clk);
    evtValid = 1'b1; evtKind = 3'd1; regSel = 1'b0; regWrEn = 1'b1; regWrData = 32'h000C_0000;
    @(negedge clk);
    evtValid = 1'b0; regWrEn = 1'b0;
    readReg(1'b0, v); check(11, "set wins, other clear applies", v, 32'h0008_0000);

    // R5 / R6 / R7 / R9 address register life
    doReset();
    pulse(3'd5, 1'b1, 32'hA5A5_0040, 2'd0, 1'b0, 1'b0);
    pulse(3'd1, 1'b0, 32'h0, 2'd0, 1'b0, 1'b0);
    pulse(3'd7, 1'b0, 32'h0, 2'd0, 1'b0, 1'b0);
    readReg(1'b0, v); check(6, "mm fault drops valid only", v, 32'h0008_0000);
    readReg(1'b1, v); check(6, "address kept after mm fault", v, 32'hA5A5_0040);
    writeReg(1'b1, 32'hDEAD_BEEF);
    readReg(1'b1, v); check(9, "address not writable", v, 32'hA5A5_0040);
    pulse(3'd5, 1'b1, 32'h1234_5678, 2'd0, 1'b0, 1'b0);
    pulse(3'd6, 1'b1, 32'h0BAD_0BAD, 2'd0, 1'b0, 1'b0);
    readReg(1'b1, v); check(7, "stacking fault leaves address", v, 32'h1234_5678);
    readReg(1'b0, v); check(5, "valid and stack bits", v, 32'h0008_9000);

    // R12 read latency
    doReset();
    @(negedge clk);
    regSel = 1'b0; evtValid = 1'b1; evtKind = 3'd3;
    @(negedge clk);
    evtValid = 1'b0;
    check(12, "read shows pre-event value", regRdData, 32'h0);
    @(negedge clk);
    check(12, "read shows updated value", regRdData, 32'h0002_0000);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule